// File: doc/BRIEF.md
# Four-Stage Unlockable Watchdog

This block is a watchdog peripheral behind a small memory-mapped register port. A companion reload timer counts microsecond ticks, which come from a prescaler that divides the system clock. It produces a watchdog tick each time its reload count has elapsed. The watchdog core loads a programmed period, decrements it on every watchdog tick, and counts how many times that period has run out. The first expiry can raise an interrupt. The fourth expiry can raise a system-reset request.

Software arms and pings the watchdog through one command bit. Software can stop it only after it has written a magic key to a separate key register. The key is used up by the next command write, and any other value written to the key register withdraws it. Register writes are single-cycle strobes and take effect at the next rising edge. Reads are combinational on the same address bus.

Top module: `stage_watchdog`

## Requirements
- R1: After reset, irq and sys_rst_req are low, and reads of the settings register (0x00), the status register (0x04) and the timer register (0x10) all return zero.
- R2: The settings register at 0x00 reads back as written, with the period in bits 11:4, interrupt enable in bit 12, reset enable in bit 15 and a 4-bit timer select in bits 3:0. All other bits read as zero.
- R3: The timer register at 0x10 holds an enable in bit 31, a repeat flag in bit 30 and a reload count in bits 29:0. A write loads the count. While the timer is enabled and the reload count is nonzero, it emits one watchdog tick every reload-count microsecond ticks. With the repeat flag clear, it clears its own enable after the first tick. Writing 0 stops it.
- R4: While the watchdog is running, each watchdog tick decrements the countdown. A tick that arrives when the countdown is 1 is an expiry: the countdown reloads from the period and the expiry count increments, wrapping from 3 to 0. The status register at 0x04 shows the countdown in bits 11:4 and the expiry count in bits 13:12.
- R5: Writing the command register at 0x08 with bit 0 set starts the watchdog, or pings it if it is already running. This loads the countdown with the period, clears the expiry count and clears irq.
- R6: When interrupt enable is set, irq rises on the first expiry after a start or ping. It stays high until a ping or an honoured stop.
- R7: When reset enable is set, sys_rst_req rises on the fourth expiry and stays high until rst_n is asserted. When reset enable is clear, expiries never raise it.
- R8: A command write with bit 1 set stops the watchdog only if the last write to the key register at 0x0C was exactly 0x0000C45A. A stop freezes the countdown and the expiry count and clears irq. Without that key, the stop bit has no effect.
- R9: A pending key is cleared by any command write, including a ping, and by any write of a different value to the key register.
- R10: A period of 0 behaves as a period of 1.
- R11: A command write with both bits 0 and 1 set and a valid pending key stops the watchdog rather than starting it.
- R12: One microsecond tick occurs every US_DIV system clocks, counted freely from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 5 | Byte address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | First-expiry interrupt |
| sys_rst_req | output | 1 | Sticky system-reset request |

## Verification
A write that is presented before a rising edge changes the registers at that edge. The new value can be read back at once after the edge, because the read path is combinational. The prescaler, the timer tick, the countdown, irq and sys_rst_req all change on the same edge as the microsecond tick that causes them, so no result lags its cause by more than that one edge. The bench drives inputs on falling edges and steps its behavioural model on each rising edge. One nanosecond later it compares reg_rdata, irq and sys_rst_req against the model, which puts every comparison in the cycle where the result is first due.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int PERIOD_W = 8;
  localparam int EXPCNT_W = 2;
  localparam int RELOAD_W = 30;
  localparam int SEL_W    = 4;

  localparam logic [ADDR_W-1:0] A_SETUP  = 5'h00;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'h04;
  localparam logic [ADDR_W-1:0] A_CMD    = 5'h08;
  localparam logic [ADDR_W-1:0] A_KEY    = 5'h0C;
  localparam logic [ADDR_W-1:0] A_TIMER  = 5'h10;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_C45A;

  localparam int B_PERIOD_LO = 4;
  localparam int B_IRQ_EN    = 12;
  localparam int B_RST_EN    = 15;
  localparam int B_EXP_LO    = 12;
  localparam int B_GO        = 0;
  localparam int B_HALT      = 1;
  localparam int B_TMR_EN    = 31;
  localparam int B_TMR_REP   = 30;
endpackage

// File: rtl/us_prescaler.sv
module us_prescaler #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick
);
  generate
    if (DIV > 1) begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      assign us_tick = (cnt == CW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (us_tick) cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
      p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        us_tick |=> !us_tick);
    end else begin : g_pass
      assign us_tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wd_tick,
  output logic [DATA_W-1:0] rd_val
);
  logic                en, rep;
  logic [RELOAD_W-1:0] rel, cnt;
  logic                step;

  assign step    = en && us_tick && (rel != '0);
  assign wd_tick = step && (cnt <= RELOAD_W'(1));
  assign rd_val  = {en, rep, rel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      rep <= 1'b0;
      rel <= '0;
      cnt <= '0;
    end else if (wr) begin
      en  <= wdata[B_TMR_EN];
      rep <= wdata[B_TMR_REP];
      rel <= wdata[RELOAD_W-1:0];
      cnt <= wdata[RELOAD_W-1:0];
    end else if (step) begin
      if (cnt <= RELOAD_W'(1)) begin
        cnt <= rel;
        if (!rep) en <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_oneshot_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_tick && !rep && !wr) |=> !en);
endmodule

// File: rtl/stage_core.sv
module stage_core
  import wdog_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wd_tick,
  input  logic                go,
  input  logic                halt,
  input  logic [PERIOD_W-1:0] period,
  input  logic                irq_en,
  input  logic                rst_en,
  output logic [PERIOD_W-1:0] countdown,
  output logic [EXPCNT_W-1:0] exp_cnt,
  output logic                irq,
  output logic                rst_req
);
  localparam logic [EXPCNT_W-1:0] LAST_EXP = '1;

  logic                running;
  logic [PERIOD_W-1:0] eff_period;
  logic                expire;

  assign eff_period = (period == '0) ? PERIOD_W'(1) : period;
  assign expire     = running && !halt && !go && wd_tick
                      && (countdown <= PERIOD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      countdown <= '0;
      exp_cnt   <= '0;
      irq       <= 1'b0;
    end else if (halt) begin
      running <= 1'b0;
      irq     <= 1'b0;
    end else if (go) begin
      running   <= 1'b1;
      countdown <= eff_period;
      exp_cnt   <= '0;
      irq       <= 1'b0;
    end else if (running && wd_tick) begin
      if (expire) begin
        countdown <= eff_period;
        exp_cnt   <= exp_cnt + 1'b1;
        if (exp_cnt == '0 && irq_en) irq <= 1'b1;
      end else begin
        countdown <= countdown - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   rst_req <= 1'b0;
    else if (expire && exp_cnt == LAST_EXP && rst_en) rst_req <= 1'b1;
  end

  p_rst_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  p_irq_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (exp_cnt == EXPCNT_W'(1)));
  p_cd_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (countdown != '0));
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !go) |=> ($stable(countdown) && $stable(exp_cnt)));
endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
  import wdog_pkg::*;
#(
  parameter int US_DIV = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sys_rst_req
);
  logic [PERIOD_W-1:0] period;
  logic                irq_en, rst_en;
  logic [SEL_W-1:0]    tmr_sel;
  logic                key_armed;
  logic                us_tick, wd_tick;
  logic [DATA_W-1:0]   tmr_rd;
  logic [PERIOD_W-1:0] countdown;
  logic [EXPCNT_W-1:0] exp_cnt;
  logic                cmd_wr, go, halt;

  assign cmd_wr = reg_wr && (reg_addr == A_CMD);
  assign go     = cmd_wr && reg_wdata[B_GO];
  assign halt   = cmd_wr && reg_wdata[B_HALT] && key_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period  <= '0;
      irq_en  <= 1'b0;
      rst_en  <= 1'b0;
      tmr_sel <= '0;
    end else if (reg_wr && reg_addr == A_SETUP) begin
      period  <= reg_wdata[B_PERIOD_LO +: PERIOD_W];
      irq_en  <= reg_wdata[B_IRQ_EN];
      rst_en  <= reg_wdata[B_RST_EN];
      tmr_sel <= reg_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             key_armed <= 1'b0;
    else if (reg_wr && reg_addr == A_KEY)   key_armed <= (reg_wdata == UNLOCK_KEY);
    else if (cmd_wr)                        key_armed <= 1'b0;
  end

  us_prescaler #(.DIV(US_DIV)) i_presc (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick)
  );

  reload_timer i_timer (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .wr(reg_wr && reg_addr == A_TIMER), .wdata(reg_wdata),
    .wd_tick(wd_tick), .rd_val(tmr_rd)
  );

  stage_core i_core (
    .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .go(go), .halt(halt),
    .period(period), .irq_en(irq_en), .rst_en(rst_en),
    .countdown(countdown), .exp_cnt(exp_cnt), .irq(irq), .rst_req(sys_rst_req)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SETUP: begin
        reg_rdata[B_PERIOD_LO +: PERIOD_W] = period;
        reg_rdata[B_IRQ_EN]                = irq_en;
        reg_rdata[B_RST_EN]                = rst_en;
        reg_rdata[SEL_W-1:0]               = tmr_sel;
      end
      A_STATUS: begin
        reg_rdata[B_PERIOD_LO +: PERIOD_W] = countdown;
        reg_rdata[B_EXP_LO +: EXPCNT_W]    = exp_cnt;
      end
      A_TIMER: reg_rdata = tmr_rd;
      default: reg_rdata = '0;
    endcase
  end

  p_key_used_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !key_armed);
endmodule

// File: tb/test_stage_watchdog.sv
`timescale 1ns/1ps
module test_stage_watchdog;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = 5'h04;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sys_rst_req;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  stage_watchdog #(.US_DIV(DIV)) i_stage_watchdog (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sys_rst_req(sys_rst_req)
  );

  // behavioural reference model
  int m_pre, m_ten, m_trep, m_trel, m_tcnt;
  int m_per, m_ien, m_ren, m_sel, m_key;
  int m_run, m_cd, m_exp, m_irq, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_ten = 0; m_trep = 0; m_trel = 0; m_tcnt = 0;
      m_per = 0; m_ien = 0; m_ren = 0; m_sel = 0; m_key = 0;
      m_run = 0; m_cd = 0; m_exp = 0; m_irq = 0; m_rst = 0;
    end else begin
      int us, fire, cmd, stp, go, eff;
      us = (m_pre == DIV - 1);
      m_pre = us ? 0 : m_pre + 1;
      fire = m_ten && us && (m_trel != 0) && (m_tcnt <= 1);
      cmd = reg_wr && reg_addr == 5'h08;
      stp = cmd && reg_wdata[1] && m_key;
      go  = cmd && reg_wdata[0];
      eff = (m_per == 0) ? 1 : m_per;
      if (stp) begin m_run = 0; m_irq = 0; end
      else if (go) begin m_run = 1; m_cd = eff; m_exp = 0; m_irq = 0; end
      else if (m_run && fire) begin
        if (m_cd <= 1) begin
          m_cd = eff;
          if (m_exp == 0 && m_ien) m_irq = 1;
          if (m_exp == 3 && m_ren) m_rst = 1;
          m_exp = (m_exp + 1) % 4;
        end else m_cd = m_cd - 1;
      end
      if (reg_wr && reg_addr == 5'h10) begin
        m_ten = reg_wdata[31]; m_trep = reg_wdata[30];
        m_trel = int'(reg_wdata[29:0]); m_tcnt = m_trel;
      end else if (m_ten && us && m_trel != 0) begin
        if (m_tcnt <= 1) begin m_tcnt = m_trel; if (!m_trep) m_ten = 0; end
        else m_tcnt = m_tcnt - 1;
      end
      if (reg_wr && reg_addr == 5'h00) begin
        m_per = int'(reg_wdata[11:4]); m_ien = reg_wdata[12];
        m_ren = reg_wdata[15]; m_sel = int'(reg_wdata[3:0]);
      end
      if (reg_wr && reg_addr == 5'h0C) m_key = (reg_wdata == 32'h0000_C45A);
      else if (cmd) m_key = 0;
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [31:0] v = '0;
    case (a)
      5'h00: begin v[11:4] = 8'(m_per); v[12] = 1'(m_ien); v[15] = 1'(m_ren); v[3:0] = 4'(m_sel); end
      5'h04: begin v[11:4] = 8'(m_cd); v[13:12] = 2'(m_exp); end
      5'h10: begin v[31] = 1'(m_ten); v[30] = 1'(m_trep); v[29:0] = 30'(m_trel); end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // cycle compare, one ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check("R3 R4 R12 model rdata", reg_rdata, m_read(reg_addr));
      check("R6 model irq", 32'(irq), 32'(m_irq));
      check("R7 model sys_rst_req", 32'(sys_rst_req), 32'(m_rst));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 5'h04; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata; reg_addr = 5'h04;
  endtask

  logic [31:0] v1, v2;

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    rd(5'h00, v1); check("R1 setup reset", v1, 32'h0);
    rd(5'h04, v1); check("R1 status reset", v1, 32'h0);
    rd(5'h10, v1); check("R1 timer reset", v1, 32'h0);
    check("R1 irq reset", 32'(irq), 32'h0);
    check("R1 rst reset", 32'(sys_rst_req), 32'h0);

    // R2 layout: period 3, irq enable, select 5, reset enable off for now
    wr(5'h00, 32'h0000_1035);
    rd(5'h00, v1); check("R2 setup readback", v1, 32'h0000_1035);
    wr(5'h10, 32'hC000_0002);
    rd(5'h10, v1); check("R3 timer readback", v1, 32'hC000_0002);

    wr(5'h08, 32'h1);
    rd(5'h04, v1); check("R5 start loads period", v1, 32'h0000_0030);
    cyc(40);
    check("R6 irq after first expiry", 32'(irq), 32'h1);
    cyc(30);
    check("R6 irq held", 32'(irq), 32'h1);
    wr(5'h08, 32'h1);
    check("R5 ping clears irq", 32'(irq), 32'h0);
    rd(5'h04, v1); check("R5 ping reloads", v1, 32'h0000_0030);

    // R7 reset disabled: run many expiries
    cyc(150);
    check("R7 no reset when disabled", 32'(sys_rst_req), 32'h0);

    // R8 stop without key is ignored
    wr(5'h08, 32'h2);
    rd(5'h04, v1); cyc(10); rd(5'h04, v2);
    check("R8 stop without key ignored", 32'(v1 != v2), 32'h1);
    // R9 bad key clears pending key
    wr(5'h0C, 32'h0000_C45A); wr(5'h0C, 32'h0000_1234); wr(5'h08, 32'h2);
    rd(5'h04, v1); cyc(10); rd(5'h04, v2);
    check("R9 bad key withdraws unlock", 32'(v1 != v2), 32'h1);
    // R9 ping consumes key
    wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'h1); wr(5'h08, 32'h2);
    rd(5'h04, v1); cyc(10); rd(5'h04, v2);
    check("R9 ping consumes unlock", 32'(v1 != v2), 32'h1);
    // R8 honoured stop
    cyc(30);
    wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'h2);
    check("R8 stop clears irq", 32'(irq), 32'h0);
    rd(5'h04, v1); cyc(20); rd(5'h04, v2);
    check("R8 stop freezes countdown", v2, v1);

    // R11 both bits with key: stop wins
    wr(5'h08, 32'h1);
    wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'h3);
    rd(5'h04, v1); cyc(20); rd(5'h04, v2);
    check("R11 stop beats start", v2, v1);

    // R10 period zero acts as one
    wr(5'h00, 32'h0000_0000);
    wr(5'h08, 32'h1);
    rd(5'h04, v1); check("R10 period zero loads one", v1, 32'h0000_0010);
    cyc(20);
    check("R10 no irq when disabled", 32'(irq), 32'h0);

    // R7 reset on fourth expiry, sticky
    wr(5'h00, 32'h0000_8010);
    wr(5'h08, 32'h1);
    cyc(20);
    check("R7 no reset before fourth", 32'(sys_rst_req), 32'h0);
    cyc(25);
    check("R7 reset on fourth expiry", 32'(sys_rst_req), 32'h1);
    wr(5'h08, 32'h1);
    check("R7 reset sticky over ping", 32'(sys_rst_req), 32'h1);

    // R3 one-shot timer clears its enable
    wr(5'h10, 32'h8000_0001);
    cyc(10);
    rd(5'h10, v1); check("R3 one-shot self clears", v1, 32'h0000_0001);
    // R3 writing zero stops ticks
    wr(5'h10, 32'hC000_0001);
    cyc(6);
    wr(5'h10, 32'h0);
    rd(5'h04, v1); cyc(20); rd(5'h04, v2);
    check("R3 zero write stops timer", v2, v1);

    // R1 reset clears sticky request
    @(negedge clk); rst_n = 1'b0;
    cyc(2);
    check("R1 reset clears request", 32'(sys_rst_req), 32'h0);
    rst_n = 1'b1;
    cyc(2);
    rd(5'h00, v1); check("R1 setup after reset", v1, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule